// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write strobes for one ATA channel that carries two drives running programmed I/O. Software turns drive timing from nanoseconds into bus clocks and writes the results into small configuration registers. A host request then runs one transfer cycle in three phases. The address setup phase comes first. The read or write strobe is then held high for the active count. The strobe is then held low for the recovery count. A one-clock done pulse ends the cycle.

The active and recovery counts come from a timing byte. Four timing bytes are held in two banks, and each bank has one byte for reads and one for writes. A bank map register picks which bank serves each drive. The address setup count is one shared field that covers both drives. A read prefetch enable bit in the same register is passed straight to an output.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset the block is idle and both strobes, busy, done and prefetch_en are low. Every timing byte resets to 0xFF, the bank map to 2'b10 and the setup field to 3. The first cycle after reset therefore runs setup 4, active 16 and recovery 17 clocks.
- R2: In a timing byte, bits 7:4 hold the active length minus 1 (1 to 16 clocks) and bits 3:0 hold the recovery length minus 2 (2 to 17 clocks).
- R3: The shared register at address 5 holds the address setup length minus 1 (1 to 4 clocks) in bits 5:4. The same setup length is used for both drives.
- R4: Once a start is accepted, busy is high from the next clock. The cycle runs setup clocks with no strobe, then active clocks with the strobe high, then recovery clocks with the strobe low, and then exactly one clock with done high. Busy falls on the clock after done.
- R5: A read cycle (req_write=0) drives ior only. A write cycle (req_write=1) drives iow only. The two strobes are never high together.
- R6: The timing bytes sit at addresses 0 to 3, where address = 2*bank + write. Bank A is 0 and bank B is 1. The byte is chosen from the request's direction and its drive's bank.
- R7: The bank map register at address 4 has bit 0 as the bank for drive 0 and bit 1 as the bank for drive 1.
- R8: prefetch_en follows bit 6 of the register at address 5, one clock after that register is written.
- R9: A start that arrives while busy is high, including the done clock, is ignored.
- R10: Configuration writes made during a cycle leave that cycle's timing unchanged. They take effect at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| req_start | input | 1 | Start a transfer cycle when idle |
| req_drv | input | 1 | Drive select, 0 or 1 |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| ior | output | 1 | Read strobe, active high |
| iow | output | 1 | Write strobe, active high |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse at the end of a cycle |
| prefetch_en | output | 1 | Read prefetch enable from the shared register |

## Verification
The embedded assertions check several rules on every clock. The two strobes never overlap, and a strobe appears only while busy is high. Done lasts exactly one clock and busy drops right after it. An accepted start opens the cycle without a strobe, and busy stays up until done. No strobe falls straight into done. Prefetch_en tracks its register bit. Other behaviour appears only through the bench scenarios checked against the clock-by-clock model. These cover the exact phase lengths for each encoding, the choice of timing byte by bank and direction, the bank map swap, the reset defaults, and the fact that a write made mid-cycle only affects the following cycle.

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       req_start,
  input  logic       req_drv,
  input  logic       req_write,
  output logic       ior,
  output logic       iow,
  output logic       busy,
  output logic       done,
  output logic       prefetch_en
);

  localparam int TW = 8;
  localparam int CW = 5;

  typedef enum logic [2:0] {IDLE, SETUP, ACT, REC, FIN} phase_t;

  logic [TW-1:0] tmg [4];
  logic [1:0]    bank_map;
  logic [1:0]    setup_f;
  logic          pf_q;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [TW-1:0] lat;
  logic          lat_wr;
  logic [TW-1:0] sel;

  assign sel = tmg[{bank_map[req_drv], req_write}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tmg[i] <= 8'hFF;
      bank_map <= 2'b10;
      setup_f  <= 2'd3;
      pf_q     <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0, 3'd1, 3'd2, 3'd3: tmg[cfg_addr[1:0]] <= cfg_wdata;
        3'd4: bank_map <= cfg_wdata[1:0];
        3'd5: begin
          setup_f <= cfg_wdata[5:4];
          pf_q    <= cfg_wdata[6];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= IDLE;
      cnt    <= '0;
      lat    <= '0;
      lat_wr <= 1'b0;
    end else begin
      case (phase)
        IDLE: if (req_start) begin
          phase  <= SETUP;
          cnt    <= {3'b000, setup_f};
          lat    <= sel;
          lat_wr <= req_write;
        end
        SETUP: if (cnt == '0) begin
          phase <= ACT;
          cnt   <= {1'b0, lat[7:4]};
        end else cnt <= cnt - 1'b1;
        ACT: if (cnt == '0) begin
          phase <= REC;
          cnt   <= {1'b0, lat[3:0]} + 5'd1;
        end else cnt <= cnt - 1'b1;
        REC: if (cnt == '0) phase <= FIN;
             else cnt <= cnt - 1'b1;
        FIN: phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end
  end

  assign busy        = (phase != IDLE);
  assign done        = (phase == FIN);
  assign ior         = (phase == ACT) && !lat_wr;
  assign iow         = (phase == ACT) && lat_wr;
  assign prefetch_en = pf_q;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ior && iow));

  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ior || iow) |-> busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_start_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start) |=> (busy && !ior && !iow));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_rec_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ior || iow) |-> (busy && !done));

  assert_prefetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd5) |=> (prefetch_en == $past(cfg_wdata[6])));

endmodule

// File: tb/sim_pio_strobe_timer.sv
`timescale 1ns/1ps
module sim_pio_strobe_timer;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic req_start = 0, req_drv = 0, req_write = 0;
  logic ior, iow, busy, done, prefetch_en;

  always #2 clk = ~clk;

  pio_strobe_timer u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_start(req_start), .req_drv(req_drv), .req_write(req_write),
    .ior(ior), .iow(iow), .busy(busy), .done(done), .prefetch_en(prefetch_en));

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R1";

  int sh_t[4]; int sh_map[2]; int sh_setup; int sh_pf;
  int k = 0, tot = 0, s = 0, a = 0, r = 0; bit wr_m = 0;

  // Behavioural reference: k counts clocks into the running cycle (0 = idle)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) sh_t[i] = 255;
      sh_map[0] = 0; sh_map[1] = 1; sh_setup = 4; sh_pf = 0; k = 0; tot = 0;
    end else begin
      if (k != 0) begin
        k = k + 1;
        if (k > tot) k = 0;
      end else if (req_start) begin
        int b;
        b = sh_t[sh_map[req_drv] * 2 + (req_write ? 1 : 0)];
        s = sh_setup; a = b / 16 + 1; r = b % 16 + 2;
        tot = s + a + r + 1; k = 1; wr_m = req_write;
      end
      if (cfg_we) begin
        if (cfg_addr < 4) sh_t[cfg_addr] = cfg_wdata;
        else if (cfg_addr == 4) begin sh_map[0] = cfg_wdata[0]; sh_map[1] = cfg_wdata[1]; end
        else if (cfg_addr == 5) begin sh_setup = cfg_wdata[5:4] + 1; sh_pf = cfg_wdata[6]; end
      end
    end
  end

  always @(negedge clk) begin
    bit e_busy, e_done, e_str;
    cycles++;
    if (rst_n) begin
      e_busy = (k != 0);
      e_str  = (k > s) && (k <= s + a) && e_busy;
      e_done = e_busy && (k == tot);
      compared++;
      if (busy !== e_busy || done !== e_done || ior !== (e_str && !wr_m) ||
          iow !== (e_str && wr_m) || prefetch_en !== sh_pf[0]) begin
        mismatched++;
        $display("FAIL %s t=%0t got busy%b done%b ior%b iow%b pf%b exp busy%b done%b ior%b iow%b pf%b",
          tag, $time, busy, done, ior, iow, prefetch_en, e_busy, e_done,
          e_str && !wr_m, e_str && wr_m, sh_pf[0]);
      end
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cfg(input int ad, input int dat);
    @(negedge clk); cfg_we = 1; cfg_addr = ad[2:0]; cfg_wdata = dat[7:0];
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(input bit drv, input bit wr);
    @(negedge clk); req_start = 1; req_drv = drv; req_write = wr;
    @(negedge clk); req_start = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (busy !== 0 || ior !== 0 || iow !== 0 || done !== 0 || prefetch_en !== 0) begin
      mismatched++;
      $display("FAIL R1 reset outputs got %b%b%b%b%b exp 00000", busy, ior, iow, done, prefetch_en);
    end
    rst_n = 1;
    tag = "R1"; run(0, 0); run(1, 1);
    tag = "R2"; cfg(0, 8'h00); run(0, 0); cfg(0, 8'h3A); run(0, 0); cfg(0, 8'hF0); run(0, 0);
    tag = "R3"; cfg(5, 8'h00); run(0, 0); run(1, 0); cfg(5, 8'h20); run(1, 1);
    tag = "R5"; cfg(1, 8'h21); run(0, 1); run(0, 0);
    tag = "R6"; cfg(0, 8'h10); cfg(1, 8'h23); cfg(2, 8'h45); cfg(3, 8'h07);
    run(0, 0); run(0, 1); run(1, 0); run(1, 1);
    tag = "R7"; cfg(4, 8'h01); run(0, 0); run(1, 1); cfg(4, 8'h03); run(1, 0); cfg(4, 8'h02);
    tag = "R8"; cfg(5, 8'h40); run(0, 0); cfg(5, 8'h10); run(0, 0);
    tag = "R9";
    @(negedge clk); req_start = 1; req_drv = 1; req_write = 0;
    repeat (40) @(negedge clk);
    req_start = 0; while (busy) @(negedge clk);
    tag = "R10";
    @(negedge clk); req_start = 1; req_drv = 0; req_write = 0;
    @(negedge clk); req_start = 0;
    cfg(0, 8'h55); cfg(5, 8'h30); cfg(4, 8'h01);
    while (busy) @(negedge clk);
    run(0, 0); run(1, 0);
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule